// File: doc/BRIEF.md
# Multiplexed Address/Data External Bus Master

This block turns single read and write requests from the chip into cycles on an external bus where address and data share one set of pins. Each cycle has three phases in a fixed order. First comes an address-latch phase, in which the latch strobe is high and the address is driven. Next comes a strobe phase, in which the read or write strobe is low. Last comes a hold phase, in which chip select is still low but both strobes have been released. An optional idle window, with chip select high, can follow. The length of every phase is programmable. All lengths are counted in periods of an external clock, and that clock runs at the system clock divided by a power of two.

Two 32-bit configuration words are plain inputs held by the surrounding logic. Requests enter on a valid/ready port. The requester raises `req_valid` with the address, write data, direction and size, and must hold all of them stable until it sees `req_ready`. `req_ready` is a single-cycle acknowledge, given in the last cycle of the final hold phase. There is no other back-pressure, and the port takes no new request until that acknowledge. For a read, the returned data appears on `rsp_rdata` in the same cycle as the acknowledge, qualified by `rsp_valid`. On an 8-bit bus, a 16-bit request is carried as two byte cycles.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset, `cs_n`, `rd_n` and `wr_n` are 1, and `ale`, `ad_oe` and `req_ready` are 0.
- R2: While `cfg_ctrl[0]` is 0, no cycle starts: `cs_n` stays 1, `ale` stays 0 and `req_ready` stays 0, even with `req_valid` held high.
- R3: A cycle begins with `cs_n` falling while `ale` is high. `ale` stays high for (A+1)·2^D system cycles, where A=`cfg_ctrl[18:16]` and D=`cfg_ctrl[10:8]`. During this phase `ad_oe`=1 and `ad_out` carries the beat address.
- R4: The strobe phase keeps `rd_n` (read) or `wr_n` (write) low for (T+1)·2^D cycles, where T=`cfg_timing[7:3]`. The two strobes are never low together.
- R5: The hold phase keeps `cs_n` low with both strobes high and `ale` low for (H+1)·2^D cycles, where H=`cfg_timing[10:8]`. Whenever `cs_n` is 1, both strobes are high and `ale` is low.
- R6: For a write, `ad_oe`=1 through the strobe and hold phases, and `ad_out` stays stable while `wr_n` is low. It carries `req_wdata` on a 16-bit bus (`cfg_ctrl[1]`=1). On an 8-bit bus it carries the beat's byte in bits 7:0 with bits 15:8 at zero.
- R7: For a read, `ad_oe`=0 while `rd_n` is low, and `ad_in` is sampled in the last strobe cycle. On a 16-bit bus `rsp_rdata`=`ad_in`, with bits 15:8 cleared when `req_size`=0. `rsp_valid` is high only together with `req_ready` on a read.
- R8: On an 8-bit bus, a request with `req_size`=1 (16-bit) runs two byte beats. The first beat uses address A and the low byte, and the second uses A+1 and the high byte. Read data is assembled low byte first. `cs_n` stays low between the beats, and the acknowledge follows the second beat only.
- R9: With W=`cfg_timing[15:12]`, the gap with `cs_n` high between a write and a request waiting behind it lasts 1+W·2^D cycles. With W=0 it lasts 1 cycle.
- R10: With R=`cfg_timing[27:24]` non-zero, a read that follows a read has `cs_n` high for 1+R·2^D cycles before it. The gap is 1 cycle between a read and a write in either order.
- R11: `req_ready` is high only while `req_valid` is high, and never for two cycles in a row.
- R12: `ext_clk` has a period of 2^D system cycles when D>0 and the block is enabled. It is held at 0 when D=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_ctrl | input | 32 | General control word: enable, bus width, clock divider, latch width |
| cfg_timing | input | 32 | Timing word: strobe, hold, post-write idle, read-read idle |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request acknowledged (one cycle, at completion) |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | 16 | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 1 | 1 = 16-bit, 0 = 8-bit |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 16 | Read data |
| ext_clk | output | 1 | Divided external clock |
| ale | output | 1 | Address latch strobe, active high |
| cs_n | output | 1 | Chip select, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| ad_out | output | 16 | Shared address/data lines, driven value |
| ad_oe | output | 1 | Output enable for the shared lines |
| ad_in | input | 16 | Shared address/data lines, sampled value |

## Verification
The acknowledge of a finished request and the decision to open an idle window fall on the same clock edge. After a write, the last hold cycle both raises `req_ready` and moves into the post-write gap. After a read, the next read is judged against a read-read flag that the acknowledge has only just set. These cases are provoked by issuing requests back to back, with the next request presented immediately after the acknowledge. They are judged by the exact run length of `cs_n` high before the next latch phase, and by the read data returned on the acknowledge.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ALE  = 3'd1,
    PH_ACC  = 3'd2,
    PH_HOLD = 3'd3,
    PH_GAP  = 3'd4
  } phase_t;

  typedef struct packed {
    logic       en;
    logic       bw16;
    logic [2:0] div;
    logic [2:0] t_ale;
    logic [4:0] t_acc;
    logic [2:0] t_hold;
    logic [3:0] w_gap;
    logic [3:0] rr_gap;
  } xcfg_t;

  function automatic xcfg_t unpack_cfg(input logic [31:0] ctrl, input logic [31:0] tim);
    xcfg_t c;
    c.en     = ctrl[0];
    c.bw16   = ctrl[1];
    c.div    = ctrl[10:8];
    c.t_ale  = ctrl[18:16];
    c.t_acc  = tim[7:3];
    c.t_hold = tim[10:8];
    c.w_gap  = tim[15:12];
    c.rr_gap = tim[27:24];
    return c;
  endfunction

endpackage

// File: rtl/xbus_timer.sv
module xbus_timer #(
  parameter int CW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] len,
  output logic          done
);
  logic [CW-1:0] cnt;

  // phase lasts len cycles after the loading edge; done marks its last cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= len - CW'(1);
    else if (cnt != '0)  cnt <= cnt - CW'(1);
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/xbus_clkdiv.sv
module xbus_clkdiv #(
  parameter int DW = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [2:0] div,
  output logic       ext_clk
);
  logic [DW-1:0] cnt;
  logic          tap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt <= '0;
    else if (en) cnt <= cnt + DW'(1);
  end

  always_comb begin
    tap = 1'b0;
    for (int i = 1; i <= 7; i++)
      if (int'(div) == i) tap = cnt[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_clk <= 1'b0;
    else        ext_clk <= en && (div != 3'd0) && tap;
  end
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int CNT_W    = 13,
  parameter int DIVCNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       cfg_ctrl,
  input  logic [31:0]       cfg_timing,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic              req_write,
  input  logic              req_size,
  output logic              rsp_valid,
  output logic [15:0]       rsp_rdata,
  output logic              ext_clk,
  output logic              ale,
  output logic              cs_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic [15:0]       ad_out,
  output logic              ad_oe,
  input  logic [15:0]       ad_in
);
  localparam int BUS_W = 16;

  xcfg_t       cfg;
  phase_t      state, nstate;
  logic        beat, nbeat;
  logic        to_ale, to_ale_n;
  logic        rr_flag;
  logic        load, done, ack;
  logic [CNT_W-1:0] len;
  logic [15:0] rd_q;
  logic        two_beats, last_beat;
  logic [ADDR_W-1:0] beat_addr;
  logic [CNT_W-1:0] ale_len, acc_len, hold_len, wgap_len, rrgap_len;

  function automatic logic [CNT_W-1:0] cyc(input logic [5:0] n, input logic [2:0] d);
    return CNT_W'(n) << d;
  endfunction

  assign cfg       = unpack_cfg(cfg_ctrl, cfg_timing);
  assign two_beats = !cfg.bw16 && req_size;
  assign last_beat = beat || !two_beats;
  assign beat_addr = req_addr + ADDR_W'(beat);

  assign ale_len   = cyc(6'(cfg.t_ale)  + 6'd1, cfg.div);
  assign acc_len   = cyc(6'(cfg.t_acc)  + 6'd1, cfg.div);
  assign hold_len  = cyc(6'(cfg.t_hold) + 6'd1, cfg.div);
  assign wgap_len  = cyc(6'(cfg.w_gap),  cfg.div);
  assign rrgap_len = cyc(6'(cfg.rr_gap), cfg.div);

  xbus_timer #(.CW(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load), .len(len), .done(done)
  );

  xbus_clkdiv #(.DW(DIVCNT_W)) u_div (
    .clk(clk), .rst_n(rst_n), .en(cfg.en), .div(cfg.div), .ext_clk(ext_clk)
  );

  always_comb begin
    nstate   = state;
    nbeat    = beat;
    to_ale_n = to_ale;
    load     = 1'b0;
    len      = '0;
    ack      = 1'b0;
    case (state)
      PH_IDLE: if (cfg.en && req_valid) begin
        load  = 1'b1;
        nbeat = 1'b0;
        if (!req_write && rr_flag && cfg.rr_gap != 4'd0) begin
          nstate = PH_GAP; to_ale_n = 1'b1; len = rrgap_len;
        end else begin
          nstate = PH_ALE; len = ale_len;
        end
      end
      PH_ALE: if (done) begin
        nstate = PH_ACC; load = 1'b1; len = acc_len;
      end
      PH_ACC: if (done) begin
        nstate = PH_HOLD; load = 1'b1; len = hold_len;
      end
      PH_HOLD: if (done) begin
        if (!last_beat) begin
          nstate = PH_ALE; nbeat = 1'b1; load = 1'b1; len = ale_len;
        end else begin
          ack = 1'b1;
          if (req_write && cfg.w_gap != 4'd0) begin
            nstate = PH_GAP; to_ale_n = 1'b0; load = 1'b1; len = wgap_len;
          end else begin
            nstate = PH_IDLE;
          end
        end
      end
      PH_GAP: if (done) begin
        if (to_ale) begin
          nstate = PH_ALE; load = 1'b1; len = ale_len;
        end else begin
          nstate = PH_IDLE;
        end
      end
      default: nstate = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= PH_IDLE;
      beat    <= 1'b0;
      to_ale  <= 1'b0;
      rr_flag <= 1'b0;
      rd_q    <= '0;
    end else begin
      state  <= nstate;
      beat   <= nbeat;
      to_ale <= to_ale_n;
      if (ack) rr_flag <= !req_write;
      if (state == PH_ACC && done && !req_write) begin
        if (cfg.bw16)     rd_q <= req_size ? ad_in : {8'h00, ad_in[7:0]};
        else if (!beat)   rd_q <= {8'h00, ad_in[7:0]};
        else              rd_q[15:8] <= ad_in[7:0];
      end
    end
  end

  always_comb begin
    ale    = (state == PH_ALE);
    cs_n   = !(state == PH_ALE || state == PH_ACC || state == PH_HOLD);
    rd_n   = !(state == PH_ACC && !req_write);
    wr_n   = !(state == PH_ACC &&  req_write);
    ad_oe  = ale || (req_write && (state == PH_ACC || state == PH_HOLD));
    ad_out = '0;
    if (state == PH_ALE)
      ad_out = BUS_W'(beat_addr);
    else if (ad_oe)
      ad_out = cfg.bw16 ? req_wdata : {8'h00, (beat ? req_wdata[15:8] : req_wdata[7:0])};
  end

  assign req_ready = ack;
  assign rsp_valid = ack && !req_write;
  assign rsp_rdata = rd_q;
endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk
  import xbus_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] cfg_ctrl,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_write,
  input logic        rsp_valid,
  input logic        ale,
  input logic        cs_n,
  input logic        rd_n,
  input logic        wr_n,
  input logic [15:0] ad_out,
  input logic        ad_oe,
  input phase_t      state
);
  assert_disabled_stays_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_IDLE && !cfg_ctrl[0]) |=> cs_n);

  assert_cycle_opens_with_ale_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> ale);

  assert_strobes_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  assert_cs_frames_strobes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (rd_n && wr_n && !ale));

  assert_write_drives_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ad_oe);

  assert_write_data_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && $past(!wr_n)) |-> $stable(ad_out));

  assert_read_releases_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);

  assert_rsp_only_on_read_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (req_ready && !req_write));

  assert_ready_needs_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> req_valid);

  assert_ready_single_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);
endmodule

bind xbus_ctrl xbus_ctrl_chk u_chk (.*);

// File: tb/sim_xbus_ctrl.sv
`timescale 1ns/1ps
module sim_xbus_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_ctrl = '0, cfg_timing = '0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_size = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic        req_ready, rsp_valid, ext_clk, ale, cs_n, rd_n, wr_n, ad_oe;
  logic [15:0] rsp_rdata, ad_out, ad_in, lat;

  int nchk = 0, nfail = 0;

  always #4 clk = ~clk;

  xbus_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_ctrl(cfg_ctrl), .cfg_timing(cfg_timing),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_write(req_write), .req_size(req_size),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ext_clk(ext_clk),
    .ale(ale), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in)
  );

  function automatic logic [15:0] dev(input logic [15:0] a);
    return {a[7:0] ^ 8'hC3, a[7:0] ^ 8'h5A};
  endfunction

  // external device: latches address on ale, returns a pattern of it
  always_ff @(posedge clk) if (ale) lat <= ad_out;
  assign ad_in = dev(lat);

  // bus monitor, sampled on the falling edge
  int nale = 0, ale_run = 0, s_run = 0, h_run = 0, c_run = 0, e_run = 0;
  int last_ale = 0, last_str = 0, last_hold = 0, last_cs = 0, last_eper = 0;
  logic p_ale = 0, p_str = 0, p_hld = 0, p_cs = 1, p_ext = 0;
  logic [15:0] acap [4];
  logic [15:0] wcap [4];
  always @(negedge clk) begin
    logic strb, hld;
    strb = !rd_n || !wr_n;
    hld  = !cs_n && !ale && rd_n && wr_n;
    if (ale) begin
      if (!p_ale) begin nale++; ale_run = 0; end
      ale_run++; acap[nale % 4] = ad_out;
    end else if (p_ale) last_ale = ale_run;
    if (strb) begin
      if (!p_str) s_run = 0;
      s_run++;
      if (!wr_n) wcap[nale % 4] = ad_out;
    end else if (p_str) last_str = s_run;
    if (hld) begin
      if (!p_hld) h_run = 0;
      h_run++;
    end else if (p_hld) last_hold = h_run;
    if (cs_n) begin
      if (!p_cs) c_run = 0;
      c_run++;
    end else if (p_cs) last_cs = c_run;
    if (ext_clk && !p_ext) begin last_eper = e_run; e_run = 1; end
    else e_run++;
    p_ale = ale; p_str = strb; p_hld = hld; p_cs = cs_n; p_ext = ext_clk;
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_req(input logic wr, input logic sz, input logic [15:0] a,
                        input logic [15:0] d, output logic [15:0] rd, output logic rv);
    int n;
    bit got;
    req_write = wr; req_size = sz; req_addr = a; req_wdata = d; req_valid = 1'b1;
    n = 0; got = 0;
    while (!got && n < 20000) begin
      @(negedge clk);
      if (req_ready) got = 1;
      n++;
    end
    if (!got) chk("R11 request never acknowledged", 0, 1);
    rd = rsp_rdata; rv = rsp_valid;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  // {ctrl, timing, write, size, addr, wdata}
  localparam logic [97:0] VEC [6] = '{
    {32'h0000_0003, 32'h0000_0000, 1'b0, 1'b1, 16'h1234, 16'h0000},
    {32'h0002_0103, 32'h0000_0118, 1'b1, 1'b1, 16'h0040, 16'hBEEF},
    {32'h0001_0001, 32'h0000_0210, 1'b0, 1'b1, 16'h00FE, 16'h0000},
    {32'h0000_0201, 32'h0000_0008, 1'b1, 1'b1, 16'h0101, 16'hA55A},
    {32'h0000_0001, 32'h0000_0020, 1'b0, 1'b0, 16'h0033, 16'h0000},
    {32'h0003_0003, 32'h0000_07F8, 1'b0, 1'b0, 16'h7788, 16'h0000}
  };

  initial begin
    #(8 * 200000);
    chk("watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    logic rv;
    int base;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 cs_n", cs_n, 1); chk("R1 rd_n", rd_n, 1); chk("R1 wr_n", wr_n, 1);
    chk("R1 ale", ale, 0); chk("R1 ad_oe", ad_oe, 0); chk("R1 req_ready", req_ready, 0);
    @(posedge clk); #1 rst_n = 1'b1;

    // R2 disabled: valid held, nothing happens
    begin
      int seen;
      seen = 0; base = nale;
      req_write = 0; req_size = 1; req_addr = 16'h0555; req_valid = 1;
      repeat (40) begin @(negedge clk); if (req_ready || !cs_n) seen++; end
      chk("R2 no strobe or ack while disabled", seen, 0);
      chk("R2 no latch phase while disabled", nale - base, 0);
      @(posedge clk); #1 req_valid = 0;
    end

    for (int i = 0; i < 6; i++) begin
      logic [31:0] c, t;
      logic wr, sz, two;
      logic [15:0] a, d, exp_rd;
      int dv;
      c = VEC[i][97:66]; t = VEC[i][65:34]; wr = VEC[i][33]; sz = VEC[i][32];
      a = VEC[i][31:16]; d = VEC[i][15:0];
      cfg_ctrl = c; cfg_timing = t;
      repeat (2) @(posedge clk); #1;
      base = nale;
      do_req(wr, sz, a, d, rd, rv);
      repeat (3) @(negedge clk);
      dv = int'(c[10:8]);
      two = !c[1] && sz;
      chk("R8 beat count", nale - base, two ? 2 : 1);
      chk("R3 latch length", last_ale, (int'(c[18:16]) + 1) << dv);
      chk("R4 strobe length", last_str, (int'(t[7:3]) + 1) << dv);
      chk("R5 hold length", last_hold, (int'(t[10:8]) + 1) << dv);
      chk("R3 address on bus", acap[(base + 1) % 4], a);
      if (two) chk("R8 second beat address", acap[(base + 2) % 4], a + 16'd1);
      if (wr) begin
        chk("R6 no rsp on write", rv, 0);
        if (c[1]) chk("R6 16-bit write data", wcap[(base + 1) % 4], d);
        else begin
          chk("R6 low byte first", wcap[(base + 1) % 4], {8'h00, d[7:0]});
          if (two) chk("R8 high byte second", wcap[(base + 2) % 4], {8'h00, d[15:8]});
        end
      end else begin
        if (c[1])     exp_rd = sz ? dev(a) : {8'h00, dev(a)[7:0]};
        else if (two) exp_rd = {dev(a + 16'd1)[7:0], dev(a)[7:0]};
        else          exp_rd = {8'h00, dev(a)[7:0]};
        chk("R7 rsp_valid on read ack", rv, 1);
        chk(two ? "R8 assembled read data" : "R7 read data", rd, exp_rd);
      end
    end

    // R9 post-write idle, D=1, W=3 -> 1+6
    cfg_ctrl = 32'h0000_0103; cfg_timing = 32'h0000_3000;
    repeat (2) @(posedge clk); #1;
    do_req(1, 1, 16'h0200, 16'h1111, rd, rv);
    do_req(0, 1, 16'h0202, 16'h0, rd, rv);
    chk("R9 gap after write", last_cs, 7);
    chk("R7 read after write gap", rd, dev(16'h0202));

    // R10 read-read idle, D=1, R=2 -> 1+4
    cfg_timing = 32'h0200_0000;
    repeat (2) @(posedge clk); #1;
    do_req(0, 1, 16'h0300, 16'h0, rd, rv);
    do_req(0, 1, 16'h0302, 16'h0, rd, rv);
    chk("R10 gap between reads", last_cs, 5);
    do_req(1, 1, 16'h0304, 16'h2222, rd, rv);
    chk("R10 no gap read to write", last_cs, 1);
    do_req(0, 1, 16'h0306, 16'h0, rd, rv);
    chk("R9 no gap with zero write idle", last_cs, 1);

    // R12 external clock
    cfg_ctrl = 32'h0000_0201;
    repeat (24) @(posedge clk);
    @(negedge clk);
    chk("R12 ext_clk period", last_eper, 4);
    cfg_ctrl = 32'h0000_0001;
    begin
      int hi;
      hi = 0;
      repeat (12) begin @(negedge clk); if (ext_clk) hi++; end
      chk("R12 ext_clk low when undivided", hi, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule